// File: doc/BRIEF.md
# Complementary PWM Output Stage with Break Protection

This block sits between the raw compare waveform of one timer channel and its two pins: a main output and a complementary output. In normal running it derives both pins from the compare waveform and delays each turn-on edge by a programmable dead-time, counted in timer clock cycles. Each pin has its own polarity bit, and output drivers are enabled per channel.

A break event can come from an external break pin, with selectable active level, or from a clock-failure signal. It drops the master output enable at once, with no clock needed, and forces both pins to their inactive level. A small state machine then resynchronizes the master enable and runs a dead-time before it drives the programmed idle levels. A sticky break flag raises an interrupt request and a DMA request. Software can re-arm the master enable, or the block can re-arm it on the next counter overflow. Both are locked out while the break is still active.

The state machine has three states. ST_IDLE is the reset state and drives the idle levels. ST_RUN drives the dead-time waveform. ST_BRK_DT holds both pins inactive while the post-break dead-time runs. Its transitions are: ST_RUN to ST_BRK_DT when the synchronized enable is low and the dead-time is non-zero; ST_RUN to ST_IDLE when the synchronized enable is low and the dead-time is zero; ST_BRK_DT to ST_IDLE when the count expires; ST_BRK_DT or ST_IDLE to ST_RUN when the synchronized enable is high.

Top module: `pwm_brk_ctrl`

## Requirements
- R1: With `brk_en` = 0, neither `brk_pin` nor `clk_fail` has any effect: `out_master_en` stays as it was and `brk_flag` stays 0.
- R2: With `brk_en` = 1, a break is active when `brk_pin` equals `brk_pol` (1 means active-high, 0 means active-low), or when `clk_fail` is 1.
- R3: When a break becomes active, `out_master_en` falls and both pins go to their inactive level within the same clock period, before any clock edge.
- R4: After a break, both pins stay inactive until clock edge `dt_cnt`+3, counted from the first edge after the break. The idle levels appear from that edge on.
- R5: In the idle state the main pin is active when `idle_main` = 1. The complementary pin is active when `idle_comp` = 1 and `idle_main` = 0. Each pin level is its active flag XOR its polarity bit (polarity 1 means active-low).
- R6: The main and complementary pins are never both at their active level.
- R7: In running operation, call the first clock edge that samples a new level of `raw_i` edge k. The pin being turned off goes inactive at edge k. The pin being turned on goes active at edge k+`dt_cnt`. The main pin is active only for raw high with `ch_en` = 1. The complementary pin is active only for raw low with `chn_en` = 1.
- R8: With `out_master_en` = 1, `oe_main` = `ch_en` and `oe_comp` = `chn_en`. With `out_master_en` = 0, `oe_main` = `fault_keep` & `ch_en` and `oe_comp` = `fault_keep` & `chn_en`.
- R9: An active break sets `brk_flag` at the next edge. `irq` = `brk_flag` & `irq_en` and `dma_req` = `brk_flag` & `dma_en`. `flag_clr` clears the flag at the next edge when no break is active.
- R10: While a break is active, `moe_set` and `flag_clr` are ignored.
- R11: With no break active, `moe_set`, or `ovf` with `auto_rearm` = 1, sets `out_master_en` at the next edge. `ovf` with `auto_rearm` = 0 does nothing.
- R12: After reset, `out_master_en` = 0, `brk_flag` = 0 and the pins show their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_i | input | 1 | Raw compare waveform |
| dt_cnt | input | DT_W | Dead-time in clock cycles |
| ch_en | input | 1 | Main channel enable |
| chn_en | input | 1 | Complementary channel enable |
| idle_main | input | 1 | Idle active flag, main pin |
| idle_comp | input | 1 | Idle active flag, complementary pin |
| pol_main | input | 1 | Main pin polarity, 1 = active-low |
| pol_comp | input | 1 | Complementary pin polarity, 1 = active-low |
| brk_en | input | 1 | Break logic enable |
| brk_pin | input | 1 | External break input |
| brk_pol | input | 1 | Active level of brk_pin |
| clk_fail | input | 1 | Clock-failure event, active high |
| fault_keep | input | 1 | Keep drivers enabled during break |
| moe_set | input | 1 | Software request to set the master enable |
| auto_rearm | input | 1 | Re-arm the master enable on overflow |
| ovf | input | 1 | Counter overflow pulse |
| flag_clr | input | 1 | Break flag clear request |
| irq_en | input | 1 | Interrupt request enable |
| dma_en | input | 1 | DMA request enable |
| out_main | output | 1 | Main output pin |
| out_comp | output | 1 | Complementary output pin |
| oe_main | output | 1 | Main driver enable |
| oe_comp | output | 1 | Complementary driver enable |
| out_master_en | output | 1 | Master output enable |
| brk_flag | output | 1 | Sticky break status |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench sweeps several dead-time values, including zero, and measures the exact edge at which each pin turns on, both in running mode and after a break. An off-by-one in the counter or in the synchronizer would show up as a pin that switches one cycle early or late. It checks the pins combinationally just after the break rises and before any clock edge. A design that cleared the master enable only on a clock would leave a pin active there. It sweeps every combination of idle bits and polarities, where a design without the priority rule would drive both pins active at once. It also pulses the set, clear and overflow inputs while the break is held, which catches a design that lets software re-arm the outputs into a live fault.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_BRK_DT = 2'd1,
        ST_IDLE   = 2'd2
    } pbc_state_e;
endpackage

// File: rtl/pbc_brk.sv
module pbc_brk #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_en,
    input  logic brk_pin,
    input  logic brk_pol,
    input  logic clk_fail,
    input  logic moe_set,
    input  logic auto_rearm,
    input  logic ovf,
    input  logic flag_clr,
    input  logic irq_en,
    input  logic dma_en,
    output logic brk_act,
    output logic moe,
    output logic moe_sync,
    output logic brk_flag,
    output logic irq,
    output logic dma_req
);
    logic              moe_q;
    logic [SYNC_N-1:0] sync_q;

    // Break detection is combinational so the enable drops without a clock.
    assign brk_act = brk_en && ((brk_pin == brk_pol) || clk_fail);
    assign moe     = moe_q && !brk_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            moe_q <= 1'b0;
        end else if (brk_act) begin
            moe_q <= 1'b0;
        end else if (moe_set || (auto_rearm && ovf)) begin
            moe_q <= 1'b1;
        end
    end

    generate
        if (SYNC_N == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= moe;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_N-2:0], moe};
            end
        end
    endgenerate
    assign moe_sync = sync_q[SYNC_N-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_flag <= 1'b0;
        end else if (brk_act) begin
            brk_flag <= 1'b1;
        end else if (flag_clr) begin
            brk_flag <= 1'b0;
        end
    end

    assign irq     = brk_flag && irq_en;
    assign dma_req = brk_flag && dma_en;

    // R9: an active break leaves the flag set
    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_act |=> brk_flag);
    // R10: the master enable stays low in the cycle after an active break
    p_moe_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_act |=> !moe);
endmodule

// File: rtl/pbc_dtgen.sv
module pbc_dtgen #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_i,
    input  logic [DT_W-1:0] dt_cnt,
    output logic            run_main,
    output logic            run_comp
);
    logic            raw_q;
    logic [DT_W-1:0] cnt_q;
    logic            settled;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            raw_q <= raw_i;
            if (raw_i != raw_q) begin
                cnt_q <= dt_cnt;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign settled  = (cnt_q == '0);
    assign run_main = raw_q && settled;
    assign run_comp = !raw_q && settled;

    // R7: a raw transition with non-zero dead-time turns both sides off first
    p_dt_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_i != raw_q) && (dt_cnt != '0)) |=> (!run_main && !run_comp));
endmodule

// File: rtl/pbc_outfsm.sv
module pbc_outfsm
    import pbc_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            moe,
    input  logic            moe_sync,
    input  logic [DT_W-1:0] dt_cnt,
    input  logic            run_main,
    input  logic            run_comp,
    input  logic            ch_en,
    input  logic            chn_en,
    input  logic            idle_main,
    input  logic            idle_comp,
    input  logic            pol_main,
    input  logic            pol_comp,
    input  logic            fault_keep,
    output logic            out_main,
    output logic            out_comp,
    output logic            oe_main,
    output logic            oe_comp
);
    pbc_state_e      state_q, state_nx;
    logic [DT_W-1:0] dcnt_q, dcnt_nx;
    logic            act_main, act_comp, live;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dcnt_q  <= '0;
        end else begin
            state_q <= state_nx;
            dcnt_q  <= dcnt_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        dcnt_nx  = dcnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (!moe_sync) begin
                    if (dt_cnt == '0) begin
                        state_nx = ST_IDLE;
                    end else begin
                        state_nx = ST_BRK_DT;
                        dcnt_nx  = dt_cnt;
                    end
                end
            end
            ST_BRK_DT: begin
                if (moe_sync) begin
                    state_nx = ST_RUN;
                end else if (dcnt_q <= DT_W'(1)) begin
                    state_nx = ST_IDLE;
                    dcnt_nx  = '0;
                end else begin
                    dcnt_nx = dcnt_q - 1'b1;
                end
            end
            ST_IDLE: begin
                if (moe_sync) state_nx = ST_RUN;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        live     = (state_q == ST_RUN) && moe;
        act_main = 1'b0;
        act_comp = 1'b0;
        if (live) begin
            act_main = run_main && ch_en;
            act_comp = run_comp && chn_en;
        end else if (state_q == ST_IDLE) begin
            act_main = idle_main;
            act_comp = idle_comp && !idle_main;
        end
        out_main = act_main ^ pol_main;
        out_comp = act_comp ^ pol_comp;
        oe_main  = ch_en && (moe || fault_keep);
        oe_comp  = chn_en && (moe || fault_keep);
    end

    // R6: pins never both at active level
    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !((out_main ^ pol_main) && (out_comp ^ pol_comp)));
    // R4: a lost synchronized enable always takes the FSM out of running
    p_leave_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !moe_sync) |=> (state_q != ST_RUN));
    // R4: the dead-time state never drives an active level
    p_dt_safe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BRK_DT) |-> (!(out_main ^ pol_main) && !(out_comp ^ pol_comp)));
endmodule

// File: rtl/pwm_brk_ctrl.sv
module pwm_brk_ctrl #(
    parameter int DT_W   = 8,
    parameter int SYNC_N = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_i,
    input  logic [DT_W-1:0] dt_cnt,
    input  logic            ch_en,
    input  logic            chn_en,
    input  logic            idle_main,
    input  logic            idle_comp,
    input  logic            pol_main,
    input  logic            pol_comp,
    input  logic            brk_en,
    input  logic            brk_pin,
    input  logic            brk_pol,
    input  logic            clk_fail,
    input  logic            fault_keep,
    input  logic            moe_set,
    input  logic            auto_rearm,
    input  logic            ovf,
    input  logic            flag_clr,
    input  logic            irq_en,
    input  logic            dma_en,
    output logic            out_main,
    output logic            out_comp,
    output logic            oe_main,
    output logic            oe_comp,
    output logic            out_master_en,
    output logic            brk_flag,
    output logic            irq,
    output logic            dma_req
);
    logic brk_act, moe_sync, run_main, run_comp;

    pbc_brk #(.SYNC_N(SYNC_N)) u_brk (
        .clk(clk), .rst_n(rst_n), .brk_en(brk_en), .brk_pin(brk_pin),
        .brk_pol(brk_pol), .clk_fail(clk_fail), .moe_set(moe_set),
        .auto_rearm(auto_rearm), .ovf(ovf), .flag_clr(flag_clr),
        .irq_en(irq_en), .dma_en(dma_en), .brk_act(brk_act),
        .moe(out_master_en), .moe_sync(moe_sync), .brk_flag(brk_flag),
        .irq(irq), .dma_req(dma_req)
    );

    pbc_dtgen #(.DT_W(DT_W)) u_dt (
        .clk(clk), .rst_n(rst_n), .raw_i(raw_i), .dt_cnt(dt_cnt),
        .run_main(run_main), .run_comp(run_comp)
    );

    pbc_outfsm #(.DT_W(DT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .moe(out_master_en), .moe_sync(moe_sync),
        .dt_cnt(dt_cnt), .run_main(run_main), .run_comp(run_comp),
        .ch_en(ch_en), .chn_en(chn_en), .idle_main(idle_main),
        .idle_comp(idle_comp), .pol_main(pol_main), .pol_comp(pol_comp),
        .fault_keep(fault_keep), .out_main(out_main), .out_comp(out_comp),
        .oe_main(oe_main), .oe_comp(oe_comp)
    );

    // R10: a held break keeps the flag set whatever software requests
    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && brk_act) |=> brk_flag);
    // R1: with break logic disabled a set master enable stays set
    p_no_brk_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_en && out_master_en) |=> (out_master_en || !$past(brk_en) == 1'b0 || brk_en));
endmodule

// File: tb/tb_pwm_brk_ctrl.sv
module tb_pwm_brk_ctrl;
    localparam int DT_W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic raw_i = 0, ch_en = 1, chn_en = 1, idle_main = 0, idle_comp = 1;
    logic pol_main = 0, pol_comp = 0, brk_en = 1, brk_pin = 0, brk_pol = 1;
    logic clk_fail = 0, fault_keep = 0, moe_set = 0, auto_rearm = 0, ovf = 0;
    logic flag_clr = 0, irq_en = 0, dma_en = 0;
    logic [DT_W-1:0] dt_cnt = '0;
    logic out_main, out_comp, oe_main, oe_comp, out_master_en, brk_flag, irq, dma_req;

    int n_chk = 0, n_fail = 0;

    pwm_brk_ctrl #(.DT_W(DT_W)) dut (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic arm();
        moe_set = 1; tick(); moe_set = 0;
        repeat (3) tick();
    endtask

    task automatic release_brk();
        brk_pin = ~brk_pol; clk_fail = 0; tick();
        flag_clr = 1; tick(); flag_clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (2) tick();
        rst_n = 1; tick();
        // R12: reset state
        chk("R12 moe", out_master_en, 0);
        chk("R12 flag", brk_flag, 0);
        chk("R12 main idle", out_main, 0);
        chk("R12 comp idle", out_comp, 1);

        // R7: run dead-time sweep
        for (int d = 0; d < 5; d++) begin
            dt_cnt = DT_W'(d); raw_i = 0;
            arm(); repeat (d + 2) tick();
            raw_i = 1;
            for (int n = 0; n <= d; n++) begin
                tick();
                chk("R7 comp off", out_comp, 0);
                chk("R7 main on", out_main, (n >= d) ? 1 : 0);
            end
            raw_i = 0;
            for (int n = 0; n <= d; n++) begin
                tick();
                chk("R7 main off", out_main, 0);
                chk("R7 comp on", out_comp, (n >= d) ? 1 : 0);
            end
        end
        // R7: channel enable gates the main pin
        dt_cnt = 0; ch_en = 0; raw_i = 1; repeat (2) tick();
        chk("R7 ch_en gate", out_main, 0);
        ch_en = 1; raw_i = 0; tick();

        // R8: enables while running
        for (int c = 0; c < 4; c++) begin
            ch_en = c[0]; chn_en = c[1]; #1;
            chk("R8 run oe_main", oe_main, c[0]);
            chk("R8 run oe_comp", oe_comp, c[1]);
        end
        ch_en = 1; chn_en = 1;

        // R3 / R4: break timing sweep
        for (int d = 0; d < 5; d++) begin
            dt_cnt = DT_W'(d); raw_i = 0; idle_main = 1; idle_comp = 0;
            arm(); repeat (2) tick();
            chk("R7 comp active before break", out_comp, 1);
            brk_pin = 1; #1;
            chk("R3 moe async", out_master_en, 0);
            chk("R3 comp async", out_comp, 0);
            chk("R3 main async", out_main, 0);
            repeat (2 + d) tick();
            chk("R4 still inactive", out_main, 0);
            tick();
            chk("R4 idle reached", out_main, 1);
            chk("R9 flag", brk_flag, 1);
            if (d != 4) release_brk();
        end

        // R5 / R6: idle-level and polarity sweep, break held
        for (int c = 0; c < 16; c++) begin
            idle_main = c[0]; idle_comp = c[1]; pol_main = c[2]; pol_comp = c[3]; #1;
            chk("R5 main level", out_main, c[0] ^ c[2]);
            chk("R5 comp level", out_comp, (c[1] & ~c[0]) ^ c[3]);
            chk("R6 exclusive", (out_main ^ pol_main) & (out_comp ^ pol_comp), 0);
        end
        pol_main = 0; pol_comp = 0;

        // R8: enables during break
        for (int c = 0; c < 8; c++) begin
            fault_keep = c[0]; ch_en = c[1]; chn_en = c[2]; #1;
            chk("R8 brk oe_main", oe_main, c[0] & c[1]);
            chk("R8 brk oe_comp", oe_comp, c[0] & c[2]);
        end
        fault_keep = 0; ch_en = 1; chn_en = 1;

        // R9: request outputs
        for (int c = 0; c < 4; c++) begin
            irq_en = c[0]; dma_en = c[1]; #1;
            chk("R9 irq", irq, c[0]);
            chk("R9 dma", dma_req, c[1]);
        end

        // R10: lock while break held
        moe_set = 1; tick(); moe_set = 0; #1;
        chk("R10 moe_set ignored", out_master_en, 0);
        flag_clr = 1; tick(); flag_clr = 0;
        chk("R10 flag_clr ignored", brk_flag, 1);
        auto_rearm = 1; ovf = 1; tick(); ovf = 0;
        chk("R10 ovf ignored in break", out_master_en, 0);

        // R11 / R9: release, clear, re-arm on overflow
        brk_pin = 0; tick();
        flag_clr = 1; tick(); flag_clr = 0;
        chk("R9 flag cleared", brk_flag, 0);
        chk("R9 irq low", irq, 0);
        auto_rearm = 0; ovf = 1; tick(); ovf = 0;
        chk("R11 ovf without rearm", out_master_en, 0);
        auto_rearm = 1; ovf = 1; tick(); ovf = 0; auto_rearm = 0;
        chk("R11 ovf rearm", out_master_en, 1);

        // R1: break disabled
        brk_en = 0; brk_pin = 1; clk_fail = 1; #1;
        chk("R1 moe kept", out_master_en, 1);
        repeat (2) tick();
        chk("R1 moe kept later", out_master_en, 1);
        chk("R1 no flag", brk_flag, 0);
        brk_pin = 0; clk_fail = 0; brk_en = 1; tick();

        // R2: polarity and clock failure source
        brk_pol = 0; brk_pin = 1; #1;
        chk("R2 high inactive when pol=0", out_master_en, 1);
        brk_pin = 0; #1;
        chk("R2 low active when pol=0", out_master_en, 0);
        release_brk();
        brk_pol = 1; brk_pin = 0; tick();
        flag_clr = 1; tick(); flag_clr = 0;
        moe_set = 1; tick(); moe_set = 0;
        chk("R11 moe_set", out_master_en, 1);
        clk_fail = 1; #1;
        chk("R2 clock failure", out_master_en, 0);
        tick();
        chk("R2 clock failure flag", brk_flag, 1);
        release_brk();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule